// File: doc/BRIEF.md
# Match-Action Timer with Edge Capture

This block is a 16-bit up-counting timer with a prescaler, four compare channels and one input-capture channel, all reached through a small word-addressed register port. The prescale count runs from zero up to a programmed limit. Each time it wraps, the timer count steps by one. Every compare channel checks its match value against the timer count in every clock cycle. On equality the channel can do any mix of three things: raise a sticky interrupt flag, send the count back to zero, or halt the timer.

The capture channel resynchronises an asynchronous input and detects its rising edges, falling edges, or both. On a selected edge it stores the timer count. It can also raise an interrupt flag. All flags are combined into a single interrupt line. Software clears a flag by writing 1 to its bit.

Register word addresses on `reg_addr`: 0 control, 1 prescale limit, 2 prescale count (read only), 3 timer count (read only), 4 compare action control, 5 to 8 compare values for channels 0 to 3, 9 capture control, 10 capture value (read only), 11 interrupt flags. Reads are combinational. Writes take effect at the clock edge on which `reg_wr` is high.

Top module: `match_capture_timer`

## Requirements
- R1: After reset every register reads zero, `irq` is 0 and the timer is halted. A compare value and the count that are both zero cause no action while the action control is zero.
- R2: With the run bit set and a prescale limit P (address 1), the prescale count (address 2) counts 0..P and the timer count (address 3) steps by one on each wrap, so it advances once every P+1 clocks.
- R3: The run bit is bit 0 of control (address 0). While it is 0, the timer count and the prescale count both hold their values.
- R4: Action bit 3n of address 4 enables the interrupt of channel n. While the timer count equals the channel's compare value, flag bit n (address 11) is set. If this bit is clear, a match sets no flag.
- R5: Action bit 3n+1 enables count reset for channel n. At a prescale wrap during which the timer count equals the channel's compare value, the count becomes 0 instead of stepping.
- R6: Action bit 3n+2 enables stop for channel n. When the count equals the compare value while running, the run bit is cleared by hardware and both counts hold. This hardware clear wins over a software write in the same cycle.
- R7: If a matching channel enables both reset and stop, the timer count and the prescale count go to 0, stay there, and the run bit is cleared.
- R8: Compare values (addresses 5 to 8) store bits 15:0. Bits 31:16 read as zero.
- R9: Capture control (address 9) bit 0 selects rising edges and bit 1 selects falling edges. Setting both captures on either edge. On a selected edge of the synchronised `cap_in`, the current timer count is stored at address 10. Edges that are not selected leave it unchanged.
- R10: Capture control bits 5:4 form the capture enable field. Only code 1 enables capture. Codes 0, 2 and 3 give no capture and no flag.
- R11: Capture control bit 2 enables the capture interrupt. Each capture then sets flag bit 4.
- R12: Flags are sticky. Writing 1 to a flag bit at address 11 clears it, unless the same cycle sets it again. `irq` is 1 exactly when any flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| cap_in | input | 1 | Asynchronous capture input |
| irq | output | 1 | OR of all interrupt flags |

## Verification
The assertions assume that the capture input holds each level for longer than the synchronizer depth plus one cycle. A shorter pulse can be lost, and the capture check could not tell when it should have been seen. They also assume that the prescale limit is not lowered below the current prescale count in mid-count. The stimulus changes `cap_in` only on falling clock edges and holds each level for four cycles. It programs the prescale limit and the compare values only while the timer is halted. It stops the timer at known counts before every capture, so each stored value is exact.

// File: rtl/mct_pkg.sv
package mct_pkg;

    // Per-channel compare actions; irq sits in the lowest bit of each triple.
    typedef struct packed {
        logic halt;
        logic zero;
        logic irq;
    } match_act_t;

    localparam int ACT_W = $bits(match_act_t);

    // Capture control layout.
    typedef struct packed {
        logic [1:0] code;
        logic       spare;
        logic       irq;
        logic       fall;
        logic       rise;
    } cap_ctl_t;

    localparam int CAPCTL_W = $bits(cap_ctl_t);
    localparam logic [1:0] CAP_CODE_ON = 2'd1;

    // Fixed part of the register map; the rest depends on the channel count.
    localparam int A_CTRL     = 0;
    localparam int A_PRESCALE = 1;
    localparam int A_PCOUNT   = 2;
    localparam int A_COUNT    = 3;
    localparam int A_MCTL     = 4;
    localparam int A_MATCH0   = 5;

    function automatic logic cap_armed(input cap_ctl_t c);
        return c.code == CAP_CODE_ON;
    endfunction

endpackage

// File: rtl/mct_counter.sv
module mct_counter #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PRE_W-1:0] pre_lim,
    input  logic             rst_hit,
    input  logic             stop_hit,
    output logic [CNT_W-1:0] tc,
    output logic [PRE_W-1:0] pc
);

    logic wrap;
    assign wrap = (pc >= pre_lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            tc <= '0;
            pc <= '0;
        end else if (run) begin
            if (stop_hit) begin
                if (rst_hit) begin
                    tc <= '0;
                    pc <= '0;
                end
            end else if (wrap) begin
                pc <= '0;
                tc <= rst_hit ? '0 : tc + 1'b1;
            end else begin
                pc <= pc + 1'b1;
            end
        end
    end

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(tc) && $stable(pc)));

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (run && !stop_hit && !rst_hit && wrap) |=> (tc == CNT_W'($past(tc) + 1'b1)) && (pc == '0));

    p_wrap_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (run && !stop_hit && rst_hit && wrap) |=> (tc == '0));

    p_stop_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (run && stop_hit && !rst_hit) |=> ($stable(tc) && $stable(pc)));

    p_stop_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (run && stop_hit && rst_hit) |=> (tc == '0 && pc == '0));

endmodule

// File: rtl/mct_match.sv
module mct_match
    import mct_pkg::*;
#(
    parameter int N_MATCH = 4,
    parameter int CNT_W   = 16
) (
    input  logic [CNT_W-1:0]               tc,
    input  logic [N_MATCH-1:0][CNT_W-1:0]  mval,
    input  match_act_t [N_MATCH-1:0]       acts,
    output logic [N_MATCH-1:0]             irq_hits,
    output logic                           rst_any,
    output logic                           stop_any
);

    logic [N_MATCH-1:0] eq;
    logic [N_MATCH-1:0] zero_v;
    logic [N_MATCH-1:0] halt_v;

    for (genvar g = 0; g < N_MATCH; g++) begin : g_cmp
        assign eq[g]       = (tc == mval[g]);
        assign irq_hits[g] = eq[g] & acts[g].irq;
        assign zero_v[g]   = eq[g] & acts[g].zero;
        assign halt_v[g]   = eq[g] & acts[g].halt;
    end

    assign rst_any  = |zero_v;
    assign stop_any = |halt_v;

endmodule

// File: rtl/mct_capture.sv
module mct_capture
    import mct_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_in,
    input  cap_ctl_t         ctl,
    input  logic [CNT_W-1:0] tc,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_fire
);

    // Synchronizer stages followed by one history flop for edge detection.
    logic [SYNC_STAGES:0] sh;
    logic now_lvl, prev_lvl;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[SYNC_STAGES-1:0], cap_in};
    end

    assign now_lvl  = sh[SYNC_STAGES-1];
    assign prev_lvl = sh[SYNC_STAGES];

    assign cap_fire = cap_armed(ctl) &&
                      ((ctl.rise && now_lvl && !prev_lvl) ||
                       (ctl.fall && !now_lvl && prev_lvl));

    always_ff @(posedge clk) begin
        if (rst)           cap_val <= '0;
        else if (cap_fire) cap_val <= tc;
    end

    p_cap_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !cap_fire |=> $stable(cap_val));

    p_reserved_code_r10: assert property (@(posedge clk) disable iff (rst)
        (ctl.code != CAP_CODE_ON) |=> $stable(cap_val));

endmodule

// File: rtl/match_capture_timer.sv
module match_capture_timer
    import mct_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PRE_W       = 16,
    parameter int N_MATCH     = 4,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cap_in,
    output logic              irq
);

    localparam int A_CAPCTL = A_MATCH0 + N_MATCH;
    localparam int A_CAPVAL = A_CAPCTL + 1;
    localparam int A_FLAGS  = A_CAPCTL + 2;
    localparam int FLAG_W   = N_MATCH + 1;
    localparam int MCTL_W   = ACT_W * N_MATCH;

    logic                          run;
    logic [PRE_W-1:0]              pre_lim;
    logic [MCTL_W-1:0]             mctl;
    logic [N_MATCH-1:0][CNT_W-1:0] mval;
    cap_ctl_t                      capctl;
    logic [FLAG_W-1:0]             flags;
    logic [FLAG_W-1:0]             clr_vec;
    logic [FLAG_W-1:0]             set_vec;

    logic [CNT_W-1:0]   tc;
    logic [CNT_W-1:0]   cap_val;
    logic [PRE_W-1:0]   pc;
    logic [N_MATCH-1:0] irq_hits;
    logic               rst_any;
    logic               stop_any;
    logic               cap_fire;
    match_act_t [N_MATCH-1:0] acts;

    assign acts = mctl;

    function automatic logic wr_hit(input int a);
        return reg_wr && (int'(reg_addr) == a);
    endfunction

    // Control and configuration registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= 1'b0;
            pre_lim <= '0;
            mctl    <= '0;
            capctl  <= '0;
            mval    <= '0;
        end else begin
            if (wr_hit(A_CTRL))     run     <= reg_wdata[0];
            if (run && stop_any)    run     <= 1'b0;
            if (wr_hit(A_PRESCALE)) pre_lim <= reg_wdata[PRE_W-1:0];
            if (wr_hit(A_MCTL))     mctl    <= reg_wdata[MCTL_W-1:0];
            if (wr_hit(A_CAPCTL))   capctl  <= cap_ctl_t'(reg_wdata[CAPCTL_W-1:0]);
            for (int i = 0; i < N_MATCH; i++) begin
                if (wr_hit(A_MATCH0 + i)) mval[i] <= reg_wdata[CNT_W-1:0];
            end
        end
    end

    mct_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .pre_lim  (pre_lim),
        .rst_hit  (rst_any),
        .stop_hit (stop_any),
        .tc       (tc),
        .pc       (pc)
    );

    mct_match #(.N_MATCH(N_MATCH), .CNT_W(CNT_W)) u_match (
        .tc       (tc),
        .mval     (mval),
        .acts     (acts),
        .irq_hits (irq_hits),
        .rst_any  (rst_any),
        .stop_any (stop_any)
    );

    mct_capture #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .cap_in   (cap_in),
        .ctl      (capctl),
        .tc       (tc),
        .cap_val  (cap_val),
        .cap_fire (cap_fire)
    );

    // Sticky flags: a set in the same cycle wins over a write-1 clear.
    assign clr_vec = wr_hit(A_FLAGS) ? reg_wdata[FLAG_W-1:0] : '0;
    assign set_vec = {cap_fire & capctl.irq, irq_hits};

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr_vec) | set_vec;
    end

    assign irq = |flags;

    // Read path.
    always_comb begin
        reg_rdata = '0;
        if (int'(reg_addr) == A_CTRL)     reg_rdata[0]            = run;
        if (int'(reg_addr) == A_PRESCALE) reg_rdata[PRE_W-1:0]    = pre_lim;
        if (int'(reg_addr) == A_PCOUNT)   reg_rdata[PRE_W-1:0]    = pc;
        if (int'(reg_addr) == A_COUNT)    reg_rdata[CNT_W-1:0]    = tc;
        if (int'(reg_addr) == A_MCTL)     reg_rdata[MCTL_W-1:0]   = mctl;
        if (int'(reg_addr) == A_CAPCTL)   reg_rdata[CAPCTL_W-1:0] = capctl;
        if (int'(reg_addr) == A_CAPVAL)   reg_rdata[CNT_W-1:0]    = cap_val;
        if (int'(reg_addr) == A_FLAGS)    reg_rdata[FLAG_W-1:0]   = flags;
        for (int i = 0; i < N_MATCH; i++) begin
            if (int'(reg_addr) == A_MATCH0 + i) reg_rdata[CNT_W-1:0] = mval[i];
        end
    end

    p_stop_clears_run_r6: assert property (@(posedge clk) disable iff (rst)
        (run && stop_any) |=> !run);

    p_match_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (irq_hits != '0) |=> ((flags[N_MATCH-1:0] & $past(irq_hits)) == $past(irq_hits)));

    p_flag_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        (|(flags & ~clr_vec)) |=> ((flags & $past(flags & ~clr_vec)) == $past(flags & ~clr_vec)));

    p_cap_flag_r11: assert property (@(posedge clk) disable iff (rst)
        (cap_fire && capctl.irq) |=> flags[N_MATCH]);

endmodule

// File: tb/test_match_capture_timer.sv
module test_match_capture_timer;

    localparam int AD_CTRL = 0, AD_PRE = 1, AD_PCNT = 2, AD_TC = 3, AD_MCTL = 4;
    localparam int AD_M0 = 5, AD_CAPCTL = 9, AD_CAPVAL = 10, AD_FLAGS = 11;

    logic        clk = 1'b0;
    logic        rst, reg_wr, cap_in, irq;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    match_capture_timer i_match_capture_timer (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cap_in    (cap_in),
        .irq       (irq)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = 4'(a);
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        reg_addr = 4'(a);
        #1;
        v = reg_rdata;
    endtask

    task automatic chk_reg(input string req, input string what, input int a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, what, v, exp);
    endtask

    task automatic do_reset();
        rst = 1'b1; reg_wr = 1'b0; cap_in = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        tick(3);
        for (int a = 0; a < 12; a++) chk_reg("R1", $sformatf("reg %0d after reset", a), a, 32'h0);
        check("R1", "irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_prescale();
        logic [31:0] tc0, pc0;
        do_reset();
        wr(AD_PRE, 2);
        wr(AD_CTRL, 1);
        tick(1);
        chk_reg("R2", "prescale count one clock in", AD_PCNT, 1);
        tick(2);
        chk_reg("R2", "count after first wrap", AD_TC, 1);
        tick(6);
        chk_reg("R2", "count after three wraps", AD_TC, 3);
        wr(AD_CTRL, 0);
        rd(AD_TC, tc0);
        rd(AD_PCNT, pc0);
        tick(7);
        chk_reg("R3", "count held while stopped", AD_TC, tc0);
        chk_reg("R3", "prescale held while stopped", AD_PCNT, pc0);
    endtask

    task automatic t_stop_irq();
        do_reset();
        wr(AD_M0, 5);
        wr(AD_MCTL, 32'h5);
        wr(AD_CTRL, 1);
        tick(10);
        chk_reg("R6", "count stopped at match", AD_TC, 5);
        chk_reg("R6", "run bit cleared", AD_CTRL, 0);
        chk_reg("R4", "match flag set", AD_FLAGS, 32'h1);
        check("R12", "irq with flag", {31'b0, irq}, 32'h1);
        wr(AD_FLAGS, 32'h1);
        chk_reg("R12", "flag kept while match persists", AD_FLAGS, 32'h1);
        wr(AD_M0, 9);
        wr(AD_FLAGS, 32'h1);
        tick(1);
        chk_reg("R12", "flag cleared by write one", AD_FLAGS, 32'h0);
        check("R12", "irq low after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_stop_prescaled();
        do_reset();
        wr(AD_PRE, 3);
        wr(AD_M0 + 3, 2);
        wr(AD_MCTL, 32'h800);
        wr(AD_CTRL, 1);
        tick(20);
        chk_reg("R6", "prescaled stop count", AD_TC, 2);
        chk_reg("R6", "prescaled stop prescale", AD_PCNT, 0);
        chk_reg("R6", "prescaled stop run bit", AD_CTRL, 0);
    endtask

    task automatic t_wrap_reset();
        do_reset();
        wr(AD_M0 + 1, 3);
        wr(AD_MCTL, 32'h10);
        wr(AD_CTRL, 1);
        for (int k = 1; k <= 10; k++) begin
            tick(1);
            chk_reg("R5", $sformatf("count at step %0d", k), AD_TC, k % 4);
        end
        chk_reg("R4", "no flag without irq enable", AD_FLAGS, 0);
    endtask

    task automatic t_stop_zero();
        do_reset();
        wr(AD_M0 + 2, 4);
        wr(AD_MCTL, 32'h1C0);
        wr(AD_CTRL, 1);
        tick(8);
        chk_reg("R7", "count zeroed", AD_TC, 0);
        chk_reg("R7", "prescale zeroed", AD_PCNT, 0);
        chk_reg("R7", "run cleared", AD_CTRL, 0);
        chk_reg("R4", "channel 2 flag", AD_FLAGS, 32'h4);
        tick(4);
        chk_reg("R7", "count stays zero", AD_TC, 0);
    endtask

    task automatic t_match_regs();
        do_reset();
        for (int c = 0; c < 4; c++) begin
            wr(AD_M0 + c, 32'hABCD_0000 | (32'h1111 * (c + 1)));
            chk_reg("R8", $sformatf("compare %0d width", c), AD_M0 + c, 32'h1111 * (c + 1));
        end
    endtask

    task automatic run_to(input int stop_at);
        wr(AD_M0, stop_at);
        wr(AD_CTRL, 1);
        tick(stop_at + 4);
    endtask

    task automatic edge_to(input logic lvl);
        @(negedge clk);
        cap_in = lvl;
        tick(4);
    endtask

    task automatic t_capture();
        do_reset();
        wr(AD_MCTL, 32'h4);
        run_to(7);
        chk_reg("R9", "setup count", AD_TC, 7);
        wr(AD_CAPCTL, 32'h15);
        edge_to(1'b1);
        chk_reg("R9", "rising capture", AD_CAPVAL, 7);
        chk_reg("R11", "capture flag", AD_FLAGS, 32'h10);
        check("R11", "irq on capture", {31'b0, irq}, 32'h1);
        wr(AD_FLAGS, 32'h10);
        run_to(12);
        edge_to(1'b0);
        chk_reg("R9", "falling edge ignored in rise mode", AD_CAPVAL, 7);
        chk_reg("R9", "no flag for ignored edge", AD_FLAGS, 0);
        wr(AD_CAPCTL, 32'h17);
        edge_to(1'b1);
        chk_reg("R9", "both mode rising", AD_CAPVAL, 12);
        wr(AD_FLAGS, 32'h10);
        run_to(20);
        edge_to(1'b0);
        chk_reg("R9", "both mode falling", AD_CAPVAL, 20);
        wr(AD_FLAGS, 32'h10);
        wr(AD_CAPCTL, 32'h12);
        run_to(25);
        edge_to(1'b1);
        chk_reg("R9", "rising ignored in fall mode", AD_CAPVAL, 20);
        edge_to(1'b0);
        chk_reg("R9", "fall mode capture", AD_CAPVAL, 25);
        chk_reg("R11", "no flag with irq disabled", AD_FLAGS, 0);
        run_to(30);
        for (int code = 0; code < 4; code++) begin
            if (code != 1) begin
                wr(AD_CAPCTL, (code << 4) | 32'h7);
                edge_to(1'b1);
                edge_to(1'b0);
                chk_reg("R10", $sformatf("code %0d no capture", code), AD_CAPVAL, 25);
                chk_reg("R10", $sformatf("code %0d no flag", code), AD_FLAGS, 0);
            end
        end
        wr(AD_CAPCTL, 32'h17);
        edge_to(1'b1);
        chk_reg("R10", "code 1 captures", AD_CAPVAL, 30);
    endtask

    initial begin
        t_reset_state();
        t_prescale();
        t_stop_irq();
        t_stop_prescaled();
        t_wrap_reset();
        t_stop_zero();
        t_match_regs();
        t_capture();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule